// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes for a CPU. A free-running tick strobe sets the time base, and the receiver counts 1, 16 or 64 ticks per serial bit. It finds the start bit. At the higher rates it confirms the start bit half a bit period later, so a short glitch is thrown away. It then samples each data bit, an optional parity bit and the first stop bit in the middle of its cell.

A finished character moves into a holding register and raises a data-ready flag. The next character is assembled while the CPU has not yet read the previous one. Parity, overrun and framing problems each set their own sticky flag. The flags stay set until the error-clear input is pulsed. The rate, length and parity fields can be shared with a companion transmitter and may change between frames.

Top module: `serial_async_rx`

## Requirements
- R1: After reset, `ready_o`, `perr_o`, `oerr_o` and `ferr_o` are 0 and `data_o` is 0.
- R2: `rate_sel_i` chooses the ticks per bit: 2'b01 gives 1, 2'b10 gives 16 and 2'b11 gives 64. 2'b00 holds the receiver idle, so line activity produces no character.
- R3: `len_sel_i` chooses the data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data arrives LSB first and lands in `data_o` from bit 0 upward. Bits above the chosen length read as 0.
- R4: With `par_en_i`=1, one parity bit follows the data. With `par_even_i`=1 the data bits plus the parity bit must hold an even count of ones; with 0 the count must be odd. A mismatch sets `perr_o`. With `par_en_i`=0 no parity bit is expected and `perr_o` is never set.
- R5: At 16x or 64x, a low line seen on a tick starts a check half a bit period later. If the line is high at that point, nothing is received and the receiver waits for a new falling edge. At 1x the start bit is taken on the first low tick.
- R6: If the first stop bit samples low, `ferr_o` is set. The character is still delivered and `ready_o` is still raised.
- R7: `ready_o` rises on the cycle after a character completes and falls on the cycle after a `rd_i` pulse. If a read and a completion fall in the same cycle, `ready_o` stays set.
- R8: When a character completes while `ready_o` is set and no read happens that cycle, `oerr_o` is set and the new character replaces the old one.
- R9: `perr_o`, `oerr_o` and `ferr_o` stay set until a pulse on `err_clr_i` clears all three. `err_clr_i` does not change `ready_o` or `data_o`.
- R10: `data_o` holds the previous character while the next one is being received. It changes only when a new character completes.
- R11: At 16x or 64x, a bit is sampled half a period after the start edge is detected and then every full period. Only the middle of each bit cell decides its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle oversampling strobe |
| rxd_i | input | 1 | Serial input, idle high |
| rate_sel_i | input | 2 | Ticks-per-bit select (00 off, 01 1x, 10 16x, 11 64x) |
| len_sel_i | input | 2 | Data length select (5 + value bits) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 even parity, 0 odd parity |
| rd_i | input | 1 | CPU read strobe, clears ready |
| err_clr_i | input | 1 | Clears the three error flags |
| data_o | output | 8 | Holding register contents |
| ready_o | output | 1 | Character waiting to be read |
| perr_o | output | 1 | Sticky parity error |
| oerr_o | output | 1 | Sticky overrun error |
| ferr_o | output | 1 | Sticky framing error |

## Verification
A sweep runs every rate against every length and parity mode. It uses several byte patterns and one deliberately wrong parity bit per parity mode. This separates errors in length masking, bit order, parity sense and tick counting. Separate patterns cover the rest:
- a short low pulse, which checks the false-start rejection;
- a low stop bit, which checks framing;
- an unread character followed by a second one, probed halfway through, which checks the double buffering and the overrun;
- a receiver turned off, which checks that the disabled rate ignores the line;
- data cells whose edges carry the wrong value, so that only correct mid-cell sampling recovers the byte.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 7;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    function automatic logic [CNT_W-1:0] ticks_per_bit(input logic [1:0] sel);
        case (sel)
            2'b01:   return CNT_W'(1);
            2'b10:   return CNT_W'(16);
            2'b11:   return CNT_W'(64);
            default: return '0;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] data_bits(input logic [1:0] sel);
        return IDX_W'(5) + IDX_W'(sel);
    endfunction
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame
    import rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic [1:0]        rate_sel_i,
    input  logic [1:0]        len_sel_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    output logic              done_o,
    output logic [DATA_W-1:0] char_o,
    output logic              perr_o,
    output logic              ferr_o
);
    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  shr;
        logic               par_acc;
        logic               perr_pend;
        logic               done;
        logic [DATA_W-1:0]  chr;
        logic               perr;
        logic               ferr;
    } frame_t;

    frame_t f_d, f_q;

    logic [CNT_W-1:0] div, half;
    logic [IDX_W-1:0] nbits;
    logic             sample;

    assign div   = ticks_per_bit(rate_sel_i);
    assign half  = div >> 1;
    assign nbits = data_bits(len_sel_i);

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        sample   = 1'b0;
        if (rate_sel_i == 2'b00) begin
            f_d.st  = ST_IDLE;
            f_d.cnt = '0;
        end else if (tick_i) begin
            case (f_q.st)
                ST_IDLE: begin
                    if (!rxd_i) begin
                        f_d.shr       = '0;
                        f_d.idx       = '0;
                        f_d.par_acc   = 1'b0;
                        f_d.perr_pend = 1'b0;
                        if (div == CNT_W'(1)) begin
                            f_d.st  = ST_DATA;
                            f_d.cnt = '0;
                        end else begin
                            f_d.st  = ST_START;
                            f_d.cnt = CNT_W'(1);
                        end
                    end
                end
                ST_START: begin
                    if (f_q.cnt == half) begin
                        f_d.cnt = '0;
                        f_d.st  = rxd_i ? ST_IDLE : ST_DATA;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (f_q.cnt == div - 1'b1) begin
                        f_d.cnt = '0;
                        sample  = 1'b1;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                    if (sample) begin
                        case (f_q.st)
                            ST_DATA: begin
                                f_d.shr[f_q.idx[2:0]] = rxd_i;
                                f_d.par_acc           = f_q.par_acc ^ rxd_i;
                                if (f_q.idx == nbits - 1'b1) begin
                                    f_d.st = par_en_i ? ST_PAR : ST_STOP;
                                end else begin
                                    f_d.idx = f_q.idx + 1'b1;
                                end
                            end
                            ST_PAR: begin
                                f_d.perr_pend = f_q.par_acc ^ rxd_i ^ ~par_even_i;
                                f_d.st        = ST_STOP;
                            end
                            default: begin
                                f_d.done = 1'b1;
                                f_d.chr  = f_q.shr;
                                f_d.perr = par_en_i & f_q.perr_pend;
                                f_d.ferr = ~rxd_i;
                                f_d.st   = ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.st        <= ST_IDLE;
            f_q.cnt       <= '0;
            f_q.idx       <= '0;
            f_q.shr       <= '0;
            f_q.par_acc   <= 1'b0;
            f_q.perr_pend <= 1'b0;
            f_q.done      <= 1'b0;
            f_q.chr       <= '0;
            f_q.perr      <= 1'b0;
            f_q.ferr      <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign done_o = f_q.done;
    assign char_o = f_q.chr;
    assign perr_o = f_q.perr;
    assign ferr_o = f_q.ferr;

    // R2: an off rate setting parks the receiver
    assert_off_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel_i == 2'b00) |=> (f_q.st == ST_IDLE));

    // R5: a high line at the half-period check abandons the frame
    assert_false_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_START && tick_i && f_q.cnt == half && rxd_i && rate_sel_i != 2'b00)
        |=> (f_q.st == ST_IDLE && !f_q.done));

    // R5: at 1x the start check is skipped
    assert_no_check_1x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel_i == 2'b01 && f_q.st == ST_IDLE) |=> (f_q.st != ST_START));

    // R7: completion is a single-cycle event
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.done |=> !f_q.done);
endmodule

// File: rtl/rx_hold.sv
`timescale 1ns/1ps
module rx_hold
    import rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] char_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              rd_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              perr_o,
    output logic              oerr_o,
    output logic              ferr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              perr;
        logic              oerr;
        logic              ferr;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (rd_i) h_d.ready = 1'b0;
        if (err_clr_i) begin
            h_d.perr = 1'b0;
            h_d.oerr = 1'b0;
            h_d.ferr = 1'b0;
        end
        if (load_i) begin
            h_d.data  = char_i;
            h_d.ready = 1'b1;
            h_d.oerr  = h_d.oerr | (h_q.ready & ~rd_i);
            h_d.perr  = h_d.perr | perr_i;
            h_d.ferr  = h_d.ferr | ferr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign data_o  = h_q.data;
    assign ready_o = h_q.ready;
    assign perr_o  = h_q.perr;
    assign oerr_o  = h_q.oerr;
    assign ferr_o  = h_q.ferr;

    assert_ready_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> h_q.ready);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> !h_q.ready);

    assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && h_q.ready && !rd_i) |=> h_q.oerr);

    assert_clear_errors_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !load_i) |=> (!h_q.perr && !h_q.oerr && !h_q.ferr));

    assert_sticky_perr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.perr && !err_clr_i) |=> h_q.perr);

    assert_sticky_oerr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.oerr && !err_clr_i) |=> h_q.oerr);

    assert_sticky_ferr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.ferr && !err_clr_i) |=> h_q.ferr);

    assert_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(h_q.data));
endmodule

// File: rtl/serial_async_rx.sv
`timescale 1ns/1ps
module serial_async_rx
    import rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic [1:0]        rate_sel_i,
    input  logic [1:0]        len_sel_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              rd_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              perr_o,
    output logic              oerr_o,
    output logic              ferr_o
);
    logic              line_s;
    logic              done;
    logic [DATA_W-1:0] chr;
    logic              c_perr, c_ferr;

    rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (line_s)
    );

    rx_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .rxd_i      (line_s),
        .rate_sel_i (rate_sel_i),
        .len_sel_i  (len_sel_i),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .done_o     (done),
        .char_o     (chr),
        .perr_o     (c_perr),
        .ferr_o     (c_ferr)
    );

    rx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (done),
        .char_i    (chr),
        .perr_i    (c_perr),
        .ferr_i    (c_ferr),
        .rd_i      (rd_i),
        .err_clr_i (err_clr_i),
        .data_o    (data_o),
        .ready_o   (ready_o),
        .perr_o    (perr_o),
        .oerr_o    (oerr_o),
        .ferr_o    (ferr_o)
    );

    // R4: no parity flag can come from a character received with parity off
    assert_no_perr_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !par_en_i) |-> !c_perr);
endmodule

// File: tb/tb_serial_async_rx.sv
`timescale 1ns/1ps
module tb_serial_async_rx;
    localparam int TDIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] rate_sel = 2'b10;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       rd = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] data_o;
    logic       ready_o, perr_o, oerr_o, ferr_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_async_rx dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd),
        .rate_sel_i(rate_sel), .len_sel_i(len_sel), .par_en_i(par_en),
        .par_even_i(par_even), .rd_i(rd), .err_clr_i(err_clr),
        .data_o(data_o), .ready_o(ready_o), .perr_o(perr_o),
        .oerr_o(oerr_o), .ferr_o(ferr_o)
    );

    initial begin
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc == TDIV - 1) ? 0 : tc + 1;
            tick = (tc == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic send_frame(input int div, input int nb, input logic [7:0] d,
                              input bit pen, input bit pbit, input bit sbit);
        wait_ticks(1);
        rxd = 1'b0; wait_ticks(div);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i]; wait_ticks(div);
        end
        if (pen) begin
            rxd = pbit; wait_ticks(div);
        end
        rxd = sbit; wait_ticks(div);
        rxd = 1'b1; wait_ticks(div);
        repeat (3) @(negedge clk);
    endtask

    function automatic bit good_par(input logic [7:0] d, input bit even);
        return even ? (^d) : ~(^d);
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", ready_o, 0);
        chk("R1 perr", perr_o, 0);
        chk("R1 oerr", oerr_o, 0);
        chk("R1 ferr", ferr_o, 0);
        chk("R1 data", data_o, 0);

        // Sweep of rate, length and parity (R2 R3 R4 R7)
        for (int rs = 1; rs <= 3; rs++) begin
            for (int ln = 0; ln < 4; ln++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    int div, nb, nv;
                    div = (rs == 1) ? 1 : (rs == 2) ? 16 : 64;
                    nb  = 5 + ln;
                    nv  = (rs == 3) ? 2 : 3;
                    rate_sel = 2'(rs);
                    len_sel  = 2'(ln);
                    par_en   = (pm != 0);
                    par_even = (pm == 2);
                    for (int v = 0; v < nv; v++) begin
                        logic [7:0] d, exp_d;
                        bit badp, pb;
                        d     = 8'hA5 + 8'(v * 75);
                        exp_d = d & 8'((1 << nb) - 1);
                        badp  = (pm != 0) && (v == nv - 1);
                        pb    = good_par(exp_d, pm == 2) ^ badp;
                        send_frame(div, nb, d, pm != 0, pb, 1'b1);
                        chk("R3 data", data_o, exp_d);
                        chk("R2 ready", ready_o, 1);
                        chk("R4 perr", perr_o, badp);
                        chk("R6 ferr clean", ferr_o, 0);
                        chk("R8 no overrun", oerr_o, 0);
                        pulse_rd();
                        chk("R7 read clears", ready_o, 0);
                        pulse_clr();
                    end
                end
            end
        end

        rate_sel = 2'b10; len_sel = 2'b11; par_en = 1'b0; par_even = 1'b0;
        @(negedge clk);

        // R2: off setting ignores the line
        rate_sel = 2'b00;
        send_frame(16, 8, 8'h55, 1'b0, 1'b0, 1'b1);
        chk("R2 disabled no ready", ready_o, 0);
        chk("R2 disabled data kept", data_o, 8'hA5 + 8'(75));
        rate_sel = 2'b10;
        @(negedge clk);

        // R5: false start at 16x
        wait_ticks(1);
        rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(40);
        chk("R5 false start 16x", ready_o, 0);
        send_frame(16, 8, 8'h96, 1'b0, 1'b0, 1'b1);
        chk("R5 after glitch data", data_o, 8'h96);
        pulse_rd();

        // R5: false start at 64x
        rate_sel = 2'b11;
        wait_ticks(1);
        rxd = 1'b0; wait_ticks(20); rxd = 1'b1; wait_ticks(140);
        chk("R5 false start 64x", ready_o, 0);
        rate_sel = 2'b10;
        @(negedge clk);

        // R6: low stop bit
        send_frame(16, 8, 8'h3C, 1'b0, 1'b0, 1'b0);
        chk("R6 ferr set", ferr_o, 1);
        chk("R6 ready set", ready_o, 1);
        chk("R6 data", data_o, 8'h3C);
        pulse_rd();
        chk("R9 ferr sticky", ferr_o, 1);
        pulse_clr();
        chk("R9 ferr cleared", ferr_o, 0);

        // R10 and R8: second character while the first is unread
        send_frame(16, 8, 8'h11, 1'b0, 1'b0, 1'b1);
        wait_ticks(1);
        rxd = 1'b0; wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rxd = 1'(8'hE7 >> i); wait_ticks(16);
            if (i == 3) begin
                chk("R10 data held mid frame", data_o, 8'h11);
                chk("R10 ready held mid frame", ready_o, 1);
                chk("R10 no overrun yet", oerr_o, 0);
            end
        end
        rxd = 1'b1; wait_ticks(32);
        chk("R8 overrun set", oerr_o, 1);
        chk("R8 data replaced", data_o, 8'hE7);
        pulse_clr();
        chk("R9 oerr cleared", oerr_o, 0);
        chk("R9 ready untouched", ready_o, 1);
        chk("R9 data untouched", data_o, 8'hE7);
        pulse_rd();

        // R11: only the middle of each cell carries the right value
        wait_ticks(1);
        rxd = 1'b0; wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            logic b;
            b = 1'(8'h6D >> i);
            rxd = ~b; wait_ticks(4);
            rxd = b;  wait_ticks(8);
            rxd = ~b; wait_ticks(4);
        end
        rxd = 1'b1; wait_ticks(32);
        chk("R11 centre sampling data", data_o, 8'h6D);
        chk("R11 centre sampling ferr", ferr_o, 0);
        pulse_rd();

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1900000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule